// File: doc/BRIEF.md
# Software-Generated Interrupt Acceptance Filter

This block sits in front of the per-core pending register for the sixteen software-generated interrupts. Each request carries an interrupt number, a requested group and a flag that says whether it came from the non-secure world. The filter compares the requested group with the group the interrupt is configured for. When security is enabled and the request is non-secure, it also checks a 2-bit permission level for that interrupt. The filter then either sets the interrupt's pending bit or drops the request.

The decision is made in the cycle the request strobe is high. The pending bit changes on the clock edge that samples the strobe. One cycle after every strobe, a status pair reports whether the request was taken. Software-side logic clears pending bits through a clear mask. Request generation and routing between cores happen elsewhere.

Top module: `sgi_accept_filter`

## Requirements
- R1: While `rst_n` is low at a clock edge, every pending bit and both status outputs become 0 at that edge.
- R2: `dec_valid` is high for exactly the one cycle that follows a cycle in which `req_valid` was high. It is low otherwise. During that cycle `dec_accept` is 1 when the request was taken and 0 when it was dropped.
- R3: A request that is taken sets `pend_o[n]`, where n is `req_num`, on the edge that samples the strobe. All other pending bits keep their value at that edge, except for bits cleared through R10.
- R4: A group-1 request (`req_grp` = 1) aimed at an interrupt configured as group 0 (`cfg_group[n]` = 0) is handled as a group-0 request. It is subject to the group-0 permission threshold.
- R5: A group-0 request aimed at an interrupt configured as group 1 (`cfg_group[n]` = 1) is dropped.
- R6: When `sec_disable` is 0 and `req_nonsec` is 1, the permission level of interrupt n is `access_word[2n+1:2n]`. A group-0 interrupt is taken only if that level is at least 1. A group-1 interrupt is taken only if it is at least 2.
- R7: When `sec_disable` is 1, or the request is secure (`req_nonsec` = 0), the permission level has no effect on the decision.
- R8: A request with `req_num` of 16 or more is dropped and sets no pending bit.
- R9: A dropped request changes no pending bit.
- R10: A 1 in `pend_clr[i]` clears `pend_o[i]` at the next edge. If the same bit is set by a taken request on that edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_grp | input | 1 | Requested group: 0 or 1 |
| req_num | input | 5 | Interrupt number; only 0 to 15 are valid |
| req_nonsec | input | 1 | 1 when the request is non-secure |
| sec_disable | input | 1 | 1 when security is disabled |
| cfg_group | input | 16 | Configured group per interrupt, bit n for interrupt n, 1 = group 1 |
| access_word | input | 32 | Non-secure permission levels, 2 bits per interrupt |
| pend_clr | input | 16 | Clear mask for the pending bits |
| pend_o | output | 16 | Pending bits |
| dec_valid | output | 1 | Decision status valid, one cycle after a strobe |
| dec_accept | output | 1 | 1 when the request was taken |

## Verification
The bench checks the group remap by sending a group-1 request to a group-0 interrupt with permission level 1. A design that skipped the remap would drop it. A design that kept the group-1 threshold would also drop it. The permission thresholds are tested at their exact boundaries, levels 0, 1, 2 and 3, on interrupt 15, which uses the top two bits of the access word. A wrong field offset or a comparison off by one changes the result there. Out-of-range numbers 16 and 31 would set a wrapped pending bit in a design that used only the low index bits. A set and a clear of the same bit in one cycle would leave the bit low if the priority were reversed.

// File: rtl/sgi_filter_pkg.sv
// Package: shared constants and types for the software-interrupt filter.
// Assumes two groups and a fixed set of permission thresholds.
package sgi_filter_pkg;

    typedef enum logic {
        GRP_ZERO = 1'b0,
        GRP_ONE  = 1'b1
    } sgi_grp_e;

    // Minimum non-secure permission level per configured group.
    localparam int unsigned PERM_MIN_G0 = 1;
    localparam int unsigned PERM_MIN_G1 = 2;

endpackage

// File: rtl/sgi_field_pick.sv
// Module: sgi_field_pick
// Selects the configured group and the permission field of the requested
// interrupt and flags whether the number is in range.
// Assumes NUM_W is wider than the index width, so NUM_SGI fits in req_num.
module sgi_field_pick
    import sgi_filter_pkg::*;
#(
    parameter int NUM_SGI = 16,
    parameter int FIELD_W = 2,
    parameter int NUM_W   = 5
) (
    input  logic [NUM_W-1:0]           req_num,
    input  logic [NUM_SGI-1:0]         cfg_group,
    input  logic [NUM_SGI*FIELD_W-1:0] access_word,
    output logic                       in_range,
    output sgi_grp_e                   cfg_grp,
    output logic [FIELD_W-1:0]         perm_field,
    output logic [$clog2(NUM_SGI)-1:0] idx
);
    localparam int IDX_W = $clog2(NUM_SGI);

    // Field and group selection for the addressed interrupt.
    always_comb begin
        in_range   = (req_num < NUM_W'(NUM_SGI));
        idx        = req_num[IDX_W-1:0];
        cfg_grp    = sgi_grp_e'(cfg_group[idx]);
        perm_field = access_word[idx*FIELD_W +: FIELD_W];
    end
endmodule

// File: rtl/sgi_accept_rule.sv
// Module: sgi_accept_rule
// Combinational accept/drop decision: group remap, group match and the
// non-secure permission threshold. Assumes inputs are from the same cycle.
module sgi_accept_rule
    import sgi_filter_pkg::*;
#(
    parameter int FIELD_W = 2
) (
    input  logic               req_valid,
    input  sgi_grp_e           req_grp,
    input  logic               req_nonsec,
    input  logic               sec_disable,
    input  logic               in_range,
    input  sgi_grp_e           cfg_grp,
    input  logic [FIELD_W-1:0] perm_field,
    output logic               accept
);
    sgi_grp_e eff_grp;
    logic     grp_ok;
    logic     perm_ok;
    logic     need_check;

    // Group remap then match against the configured group.
    always_comb begin
        eff_grp = req_grp;
        if (req_grp == GRP_ONE && cfg_grp == GRP_ZERO) begin
            eff_grp = GRP_ZERO;
        end
        grp_ok = (eff_grp == cfg_grp);
    end

    // Permission threshold applies only to non-secure requests with security on.
    always_comb begin
        need_check = req_nonsec && !sec_disable;
        if (!need_check) begin
            perm_ok = 1'b1;
        end else if (cfg_grp == GRP_ZERO) begin
            perm_ok = (perm_field >= FIELD_W'(PERM_MIN_G0));
        end else begin
            perm_ok = (perm_field >= FIELD_W'(PERM_MIN_G1));
        end
    end

    // Final decision.
    always_comb begin
        accept = req_valid && in_range && grp_ok && perm_ok;
    end
endmodule

// File: rtl/sgi_pend_bank.sv
// Module: sgi_pend_bank
// One pending flop per interrupt; a set on the same edge beats a clear.
// Assumes set_vec has at most one bit high.
module sgi_pend_bank #(
    parameter int NUM_SGI = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SGI-1:0] set_vec,
    input  logic [NUM_SGI-1:0] clr_vec,
    output logic [NUM_SGI-1:0] pend
);
    for (genvar i = 0; i < NUM_SGI; i++) begin : g_bit
        // Pending flop for interrupt i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend[i] <= 1'b0;
            end else if (set_vec[i]) begin
                pend[i] <= 1'b1;
            end else if (clr_vec[i]) begin
                pend[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sgi_accept_filter.sv
// Module: sgi_accept_filter (top)
// Filters software-interrupt requests and keeps their pending bits; reports
// each decision one cycle after the strobe. Synchronous active-low reset.
module sgi_accept_filter
    import sgi_filter_pkg::*;
#(
    parameter int NUM_SGI = 16,
    parameter int FIELD_W = 2,
    parameter int NUM_W   = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_grp,
    input  logic [NUM_W-1:0]           req_num,
    input  logic                       req_nonsec,
    input  logic                       sec_disable,
    input  logic [NUM_SGI-1:0]         cfg_group,
    input  logic [NUM_SGI*FIELD_W-1:0] access_word,
    input  logic [NUM_SGI-1:0]         pend_clr,
    output logic [NUM_SGI-1:0]         pend_o,
    output logic                       dec_valid,
    output logic                       dec_accept
);
    localparam int IDX_W = $clog2(NUM_SGI);

    logic               in_range;
    sgi_grp_e           cfg_grp;
    logic [FIELD_W-1:0] perm_field;
    logic [IDX_W-1:0]   idx;
    logic               accept;
    logic [NUM_SGI-1:0] set_vec;

    sgi_field_pick #(
        .NUM_SGI (NUM_SGI),
        .FIELD_W (FIELD_W),
        .NUM_W   (NUM_W)
    ) u_pick (
        .req_num     (req_num),
        .cfg_group   (cfg_group),
        .access_word (access_word),
        .in_range    (in_range),
        .cfg_grp     (cfg_grp),
        .perm_field  (perm_field),
        .idx         (idx)
    );

    sgi_accept_rule #(
        .FIELD_W (FIELD_W)
    ) u_rule (
        .req_valid   (req_valid),
        .req_grp     (sgi_grp_e'(req_grp)),
        .req_nonsec  (req_nonsec),
        .sec_disable (sec_disable),
        .in_range    (in_range),
        .cfg_grp     (cfg_grp),
        .perm_field  (perm_field),
        .accept      (accept)
    );

    // One-hot set vector for the accepted interrupt.
    for (genvar i = 0; i < NUM_SGI; i++) begin : g_set
        assign set_vec[i] = accept && (idx == IDX_W'(i));
    end

    sgi_pend_bank #(
        .NUM_SGI (NUM_SGI)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (pend_clr),
        .pend    (pend_o)
    );

    // Decision status, one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
        end else begin
            dec_valid  <= req_valid;
            dec_accept <= accept;
        end
    end
endmodule

// File: rtl/sgi_accept_filter_chk.sv
// Module: sgi_accept_filter_chk
// Port-level properties of the filter, bound to the top module.
// Assumes default widths: 2-bit fields, 5-bit request number.
module sgi_accept_filter_chk #(
    parameter int NUM_SGI = 16,
    parameter int FIELD_W = 2,
    parameter int NUM_W   = 5
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic                       req_grp,
    input logic [NUM_W-1:0]           req_num,
    input logic                       req_nonsec,
    input logic                       sec_disable,
    input logic [NUM_SGI-1:0]         cfg_group,
    input logic [NUM_SGI*FIELD_W-1:0] access_word,
    input logic [NUM_SGI-1:0]         pend_clr,
    input logic [NUM_SGI-1:0]         pend_o,
    input logic                       dec_valid,
    input logic                       dec_accept
);
    localparam int IDX_W = $clog2(NUM_SGI);

    logic               seen;
    logic [IDX_W-1:0]   cidx;
    logic [FIELD_W-1:0] cfield;

    // Marks that one post-reset cycle has passed, so $past is defined.
    always_ff @(posedge clk) begin
        seen <= rst_n;
    end

    assign cidx   = req_num[IDX_W-1:0];
    assign cfield = FIELD_W'(access_word >> (32'(cidx) * FIELD_W));

    a_r2_status_follows: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        req_valid |=> dec_valid);
    a_r2_status_idle: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        !req_valid |=> !dec_valid);
    a_r3_accept_sets: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        (dec_valid && dec_accept) |-> pend_o[$past(cidx)]);
    a_r5_grp_mismatch: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        (req_valid && !req_grp && req_num < NUM_W'(NUM_SGI) && cfg_group[cidx]) |=> !dec_accept);
    a_r6_perm_zero: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        (req_valid && req_nonsec && !sec_disable && req_num < NUM_W'(NUM_SGI) && cfield == '0) |=> !dec_accept);
    a_r8_out_of_range: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        (req_valid && req_num >= NUM_W'(NUM_SGI)) |=> (dec_valid && !dec_accept));
    a_r9_drop_no_set: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        !(dec_valid && dec_accept) |-> (pend_o == ($past(pend_o) & ~$past(pend_clr))));
endmodule

bind sgi_accept_filter sgi_accept_filter_chk #(
    .NUM_SGI (NUM_SGI),
    .FIELD_W (FIELD_W),
    .NUM_W   (NUM_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_grp     (req_grp),
    .req_num     (req_num),
    .req_nonsec  (req_nonsec),
    .sec_disable (sec_disable),
    .cfg_group   (cfg_group),
    .access_word (access_word),
    .pend_clr    (pend_clr),
    .pend_o      (pend_o),
    .dec_valid   (dec_valid),
    .dec_accept  (dec_accept)
);

// File: tb/tb_sgi_accept_filter.sv
// Bench: behavioural reference model updated every clock, outputs compared
// on every falling edge.
module tb_sgi_accept_filter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_grp;
    logic [4:0]  req_num;
    logic        req_nonsec;
    logic        sec_disable;
    logic [15:0] cfg_group;
    logic [31:0] access_word;
    logic [15:0] pend_clr;
    logic [15:0] pend_o;
    logic        dec_valid;
    logic        dec_accept;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    chk_en   = 0;
    string tag      = "R1";

    logic [15:0] m_pend;
    logic        m_valid;
    logic        m_acc;

    always #5 clk = ~clk;

    sgi_accept_filter dut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_grp (req_grp),
        .req_num (req_num), .req_nonsec (req_nonsec), .sec_disable (sec_disable),
        .cfg_group (cfg_group), .access_word (access_word), .pend_clr (pend_clr),
        .pend_o (pend_o), .dec_valid (dec_valid), .dec_accept (dec_accept)
    );

    // Reference decision written from the requirements (R4..R8).
    function automatic bit model_take(int num, int grp, bit ns, bit sd,
                                      logic [15:0] cfg, logic [31:0] acc);
        int ig;
        int lvl;
        if (num > 15) return 0;                    // R8
        ig = int'(cfg[num]);
        if (grp == 1 && ig == 0) grp = 0;          // R4
        if (grp != ig) return 0;                   // R5
        if (ns && !sd) begin                       // R6 / R7
            lvl = int'((acc >> (2 * num)) & 32'h3);
            if (ig == 0 && lvl < 1) return 0;
            if (ig == 1 && lvl < 2) return 0;
        end
        return 1;
    endfunction

    // Model state update at each rising edge.
    always @(posedge clk) begin
        bit tk;
        if (!rst_n) begin
            m_pend  <= '0;
            m_valid <= 1'b0;
            m_acc   <= 1'b0;
        end else begin
            tk = req_valid && model_take(int'(req_num), int'(req_grp), req_nonsec,
                                         sec_disable, cfg_group, access_word);
            m_valid <= req_valid;
            m_acc   <= tk;
            m_pend  <= (m_pend & ~pend_clr) | (tk ? (16'h1 << req_num[3:0]) : 16'h0);
        end
    end

    // Compare every falling edge.
    always @(negedge clk) begin
        if (chk_en) begin
            n_checks += 3;
            if (pend_o !== m_pend) begin
                n_fail++;
                $display("FAIL %s pend_o actual=%h expected=%h", tag, pend_o, m_pend);
            end
            if (dec_valid !== m_valid) begin
                n_fail++;
                $display("FAIL %s dec_valid actual=%b expected=%b", tag, dec_valid, m_valid);
            end
            if (dec_accept !== m_acc) begin
                n_fail++;
                $display("FAIL %s dec_accept actual=%b expected=%b", tag, dec_accept, m_acc);
            end
        end
    end

    // One request cycle, then the strobe drops.
    task automatic send(input string t, input bit g, input int num, input bit ns,
                        input bit sd);
        @(negedge clk);
        tag         = t;
        req_valid   = 1'b1;
        req_grp     = g;
        req_num     = 5'(num);
        req_nonsec  = ns;
        sec_disable = sd;
        @(negedge clk);
        req_valid   = 1'b0;
        pend_clr    = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_grp = 1'b0; req_num = '0;
        req_nonsec = 1'b0; sec_disable = 1'b0; pend_clr = '0;
        cfg_group   = 16'b1000_0000_1111_0000;  // 4..7 and 15 are group 1
        access_word = 32'h0000_0000;
        repeat (3) @(negedge clk);
        chk_en = 1;                              // R1: reset state checked here
        tag = "R1";
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);                                 // R2: no strobe, status low

        send("R3", 1'b0, 3, 1'b0, 1'b0);         // secure group-0 accept
        send("R3", 1'b1, 5, 1'b0, 1'b0);         // secure group-1 accept
        access_word[3:2] = 2'd1;                 // interrupt 1 level 1
        send("R4", 1'b1, 1, 1'b1, 1'b0);         // remap, level 1 suffices
        send("R4", 1'b1, 2, 1'b1, 1'b0);         // remap, level 0 drops
        send("R5", 1'b0, 6, 1'b0, 1'b0);         // group mismatch drop
        access_word[31:30] = 2'd1;
        send("R6", 1'b1, 15, 1'b1, 1'b0);        // level 1 < 2 drop
        access_word[31:30] = 2'd2;
        send("R6", 1'b1, 15, 1'b1, 1'b0);        // level 2 accept
        pend_clr = 16'h8000;
        idle(1);
        access_word[31:30] = 2'd3;
        send("R6", 1'b1, 15, 1'b1, 1'b0);        // level 3 accept
        send("R6", 1'b0, 0, 1'b1, 1'b0);         // group 0, level 0 drop
        send("R7", 1'b0, 0, 1'b1, 1'b1);         // security off: accept
        send("R7", 1'b1, 7, 1'b0, 1'b0);         // secure, level 0: accept
        send("R8", 1'b0, 16, 1'b0, 1'b0);        // out of range
        send("R8", 1'b1, 31, 1'b0, 1'b1);
        send("R9", 1'b0, 4, 1'b0, 1'b1);         // dropped, pending kept
        @(negedge clk);
        tag = "R10";
        pend_clr = 16'h0009;                     // clear 0 and 3
        @(negedge clk);
        pend_clr = 16'h0000;
        // R10: set and clear of bit 0 in the same cycle
        @(negedge clk);
        tag = "R10"; req_valid = 1'b1; req_grp = 1'b0; req_num = 5'd0;
        req_nonsec = 1'b0; sec_disable = 1'b0; pend_clr = 16'h0001;
        @(negedge clk);
        req_valid = 1'b0; pend_clr = '0;
        // R2: back-to-back strobes
        tag = "R2"; req_valid = 1'b1; req_num = 5'd8;
        @(negedge clk);
        req_num = 5'd9; req_grp = 1'b1;          // group-1 to group-0: remap, accept
        @(negedge clk);
        req_valid = 1'b0;
        idle(2);
        tag = "R1"; rst_n = 1'b0;                // R1: reset clears pending
        idle(2);
        rst_n = 1'b1;
        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule